// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache

This block sits between a processor and a slower, word-addressable main memory. The processor presents one read or write at a time with a 16-bit word address. The block answers from its own storage when it holds the addressed word. Otherwise it loads the whole 16-word block that contains the word from memory before it completes the access. Stores stay in the cache and mark their block as modified. Memory sees the modified data only when that block is displaced by another block, or when a flush is requested.

Two whole-cache operations support transfers that bypass the processor, such as DMA. A flush copies every modified block back to memory. An invalidate discards every block, so the next access to any address goes to memory again. The cache has 128 lines, and a memory block can live in only one of them. Tags, state bits and data are kept in internal register arrays.

Top module: `dmc_cache`

## Requirements
- R1: The address is split into three fields. Bits [3:0] select the word in a block, bits [10:4] select the line (memory block j goes to line j mod 128), and bits [15:11] form the tag. A refill reads the 16 words at addresses {tag, line, 0} up to {tag, line, 15}, in ascending order.
- R2: On a read miss, exactly 16 memory reads load the block, and then the requested word is returned on `cpu_rdata`.
- R3: On a read hit, the stored word is returned with no memory traffic. `cpu_ready` is high during the second clock cycle after the cycle in which the request is first presented.
- R4: After reset no line is valid. The first access to any address misses, even when its tag would match what the line holds.
- R5: A write hit changes only the cached copy. Memory keeps its old value, and later reads of that address return the written value.
- R6: On a write miss, the block is first fetched (16 reads, no writes). Then the addressed word is overwritten. The other words of the block keep their memory values.
- R7: A miss on a line that holds a modified block first writes back all 16 words of the old block to its own address. These writes all complete before the first refill read. A miss on a clean line performs no write.
- R8: The memory port moves one word per `mem_req`/`mem_ack` handshake. `mem_addr`, `mem_we` and `mem_wdata` stay stable until `mem_ack` is seen. Within a burst the word address rises by one per acknowledged word.
- R9: `cpu_ready` is high for exactly one cycle per completed request.
- R10: An invalidate marks every line not valid and discards modified data without writing it back. `maint_done` pulses when it completes. A later read refetches from memory.
- R11: A flush writes back every modified block once and performs no write for clean lines. It leaves all lines clean, so a second flush writes nothing. `maint_done` pulses at the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| flush_req | input | 1 | Start a write-back of all modified lines (priority over invalidate) |
| inval_req | input | 1 | Start a whole-cache invalidate |
| maint_done | output | 1 | One-cycle pulse at the end of a flush or invalidate |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the current word |

## Verification
The bench targets conflict misses between two tags that share a line. A design that skipped the copy-back would lose the stored word in memory. A design that wrote back clean lines would show 16 extra writes, and one that overlapped write-back with refill would show a read before the last write. Write-allocate is tested by reading a neighbour word of a freshly written block. A design that failed to allocate would return the wrong data or miss again. After reset and after an invalidate, the bench confirms that stale contents or tags never produce a hit and that discarded stores do not reach memory. A second flush must produce zero writes, which exposes a design that forgets to clear dirty bits.

// File: rtl/dmc_pkg.sv
// Shared definitions for the direct-mapped write-back cache.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dmc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for processor or maintenance request
        ST_CMP,    // tag compare and hit service
        ST_WB,     // copy-back of a displaced modified block
        ST_FILL,   // refill of the requested block
        ST_FSCAN,  // flush: inspect one line
        ST_FWB     // flush: copy back one modified line
    } dmc_state_e;
endpackage

// File: rtl/dmc_tags.sv
// Per-line valid, dirty and tag storage.
// Assumes one line index per cycle; fill, set and clear requests target idx_i.
// Invalidate clears valid and dirty of every line in one cycle.
module dmc_tags #(
    parameter int IDX_W = 7,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             fill_i,
    input  logic [TAG_W-1:0] fill_tag_i,
    input  logic             set_dirty_i,
    input  logic             clr_dirty_i,
    input  logic             inval_all_i,
    output logic             valid_o,
    output logic             dirty_o,
    output logic [TAG_W-1:0] tag_o,
    output logic [(1<<IDX_W)-1:0] valid_all_o
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // State bits: reset, whole-cache clear, fill and dirty updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (inval_all_i) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_i) begin
                valid_q[idx_i] <= 1'b1;
                dirty_q[idx_i] <= 1'b0;
            end
            if (set_dirty_i) dirty_q[idx_i] <= 1'b1;
            if (clr_dirty_i) dirty_q[idx_i] <= 1'b0;
        end
    end

    // Tag array: written only when a block is filled.
    always_ff @(posedge clk) begin
        if (fill_i) tag_q[idx_i] <= fill_tag_i;
    end

    // Combinational read of the addressed line.
    always_comb begin
        valid_o = valid_q[idx_i];
        dirty_o = dirty_q[idx_i];
        tag_o   = tag_q[idx_i];
    end

    assign valid_all_o = valid_q;
endmodule

// File: rtl/dmc_data.sv
// Cache data array: one word per (line, offset), asynchronous read,
// single synchronous write port. Assumes contents are meaningful only
// for valid lines, so no reset is applied.
module dmc_data #(
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int WORDS = 1 << (IDX_W + OFF_W);

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [IDX_W+OFF_W-1:0] addr;

    assign addr = {idx_i, off_i};

    // Write port.
    always_ff @(posedge clk) begin
        if (we_i) mem_q[addr] <= wdata_i;
    end

    // Read port.
    assign rdata_o = mem_q[addr];
endmodule

// File: rtl/dmc_ctrl.sv
// Cache controller: accepts one processor request at a time, compares the
// tag, serves hits, copies back a modified victim, refills the block, and
// runs the whole-cache flush and invalidate operations.
// Assumes the processor holds its request until cpu_ready and the memory
// holds mem_ack for one cycle per word. Flush beats invalidate beats access.
module dmc_ctrl #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              flush_req,
    input  logic              inval_req,
    output logic              maint_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [IDX_W-1:0]  ts_idx,
    input  logic              ts_valid,
    input  logic              ts_dirty,
    input  logic [ADDR_W-OFF_W-IDX_W-1:0] ts_tag,
    output logic              ts_fill,
    output logic [ADDR_W-OFF_W-IDX_W-1:0] ts_fill_tag,
    output logic              ts_set_dirty,
    output logic              ts_clr_dirty,
    output logic              ts_inval_all,
    output logic [OFF_W-1:0]  ds_off,
    output logic              ds_we,
    output logic [DATA_W-1:0] ds_wdata,
    input  logic [DATA_W-1:0] ds_rdata,
    output logic              inval_go
);
    import dmc_pkg::*;

    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam logic [OFF_W-1:0] LAST_OFF = '1;
    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    dmc_state_e        state_q;
    logic [ADDR_W-1:0] a_q;
    logic              we_q;
    logic [DATA_W-1:0] wd_q;
    logic [OFF_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  fidx_q;
    logic              ready_q;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;

    logic [TAG_W-1:0] a_tag;
    logic [IDX_W-1:0] a_idx;
    logic [OFF_W-1:0] a_off;
    logic             hit;
    logic             in_flush;
    logic             word_done;
    logic             last_word;

    assign a_tag = a_q[ADDR_W-1 -: TAG_W];
    assign a_idx = a_q[OFF_W +: IDX_W];
    assign a_off = a_q[OFF_W-1:0];

    // Line selection and hit detection.
    always_comb begin
        in_flush  = (state_q == ST_FSCAN) || (state_q == ST_FWB);
        ts_idx    = in_flush ? fidx_q : a_idx;
        hit       = ts_valid && (ts_tag == a_tag);
        word_done = mem_req && mem_ack;
        last_word = (cnt_q == LAST_OFF);
    end

    // Memory port drive: copy-back uses the stored tag, refill the request tag.
    always_comb begin
        mem_req   = (state_q == ST_WB) || (state_q == ST_FILL) || (state_q == ST_FWB);
        mem_we    = (state_q == ST_WB) || (state_q == ST_FWB);
        mem_addr  = (state_q == ST_FILL) ? {a_tag, a_idx, cnt_q} : {ts_tag, ts_idx, cnt_q};
        mem_wdata = ds_rdata;
    end

    // Storage write controls.
    always_comb begin
        ds_off       = (state_q == ST_CMP) ? a_off : cnt_q;
        ds_we        = 1'b0;
        ds_wdata     = wd_q;
        ts_fill      = 1'b0;
        ts_fill_tag  = a_tag;
        ts_set_dirty = 1'b0;
        ts_clr_dirty = 1'b0;
        inval_go     = (state_q == ST_IDLE) && !flush_req && inval_req;
        ts_inval_all = inval_go;
        if (state_q == ST_CMP && hit && we_q) begin
            ds_we        = 1'b1;
            ts_set_dirty = 1'b1;
        end
        if (state_q == ST_FILL && word_done) begin
            ds_we    = 1'b1;
            ds_wdata = mem_rdata;
            ts_fill  = last_word;
        end
        if (state_q == ST_FWB && word_done && last_word) ts_clr_dirty = 1'b1;
    end

    // Sequencer state, request capture, counters and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            a_q     <= '0;
            we_q    <= 1'b0;
            wd_q    <= '0;
            cnt_q   <= '0;
            fidx_q  <= '0;
            ready_q <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            ready_q <= 1'b0;
            done_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (flush_req) begin
                        fidx_q  <= '0;
                        state_q <= ST_FSCAN;
                    end else if (inval_req) begin
                        done_q <= 1'b1;
                    end else if (cpu_req) begin
                        a_q     <= cpu_addr;
                        we_q    <= cpu_we;
                        wd_q    <= cpu_wdata;
                        state_q <= ST_CMP;
                    end
                end
                ST_CMP: begin
                    cnt_q <= '0;
                    if (hit) begin
                        ready_q <= 1'b1;
                        rdata_q <= ds_rdata;
                        state_q <= ST_IDLE;
                    end else if (ts_valid && ts_dirty) begin
                        state_q <= ST_WB;
                    end else begin
                        state_q <= ST_FILL;
                    end
                end
                ST_WB: begin
                    if (word_done) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (last_word) state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (word_done) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (last_word) state_q <= ST_CMP;
                    end
                end
                ST_FSCAN: begin
                    cnt_q <= '0;
                    if (ts_valid && ts_dirty) begin
                        state_q <= ST_FWB;
                    end else if (fidx_q == LAST_IDX) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        fidx_q <= fidx_q + 1'b1;
                    end
                end
                ST_FWB: begin
                    if (word_done) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (last_word) begin
                            if (fidx_q == LAST_IDX) begin
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end else begin
                                fidx_q  <= fidx_q + 1'b1;
                                state_q <= ST_FSCAN;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready  = ready_q;
    assign cpu_rdata  = rdata_q;
    assign maint_done = done_q;
endmodule

// File: rtl/dmc_cache.sv
// Top of the write-back direct-mapped cache: ties the controller to the
// tag/state store and the data array.
// Assumes a single processor master and a single word-wide memory slave.
module dmc_cache #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              flush_req,
    input  logic              inval_req,
    output logic              maint_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int LINES = 1 << IDX_W;

    logic [IDX_W-1:0]  ts_idx;
    logic              ts_valid;
    logic              ts_dirty;
    logic [TAG_W-1:0]  ts_tag;
    logic              ts_fill;
    logic [TAG_W-1:0]  ts_fill_tag;
    logic              ts_set_dirty;
    logic              ts_clr_dirty;
    logic              ts_inval_all;
    logic [OFF_W-1:0]  ds_off;
    logic              ds_we;
    logic [DATA_W-1:0] ds_wdata;
    logic [DATA_W-1:0] ds_rdata;
    logic              inval_go;
    logic [LINES-1:0]  valid_all;

    dmc_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .flush_req(flush_req), .inval_req(inval_req), .maint_done(maint_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .ts_idx(ts_idx), .ts_valid(ts_valid), .ts_dirty(ts_dirty), .ts_tag(ts_tag),
        .ts_fill(ts_fill), .ts_fill_tag(ts_fill_tag), .ts_set_dirty(ts_set_dirty),
        .ts_clr_dirty(ts_clr_dirty), .ts_inval_all(ts_inval_all),
        .ds_off(ds_off), .ds_we(ds_we), .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
        .inval_go(inval_go)
    );

    dmc_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx_i(ts_idx),
        .fill_i(ts_fill), .fill_tag_i(ts_fill_tag),
        .set_dirty_i(ts_set_dirty), .clr_dirty_i(ts_clr_dirty), .inval_all_i(ts_inval_all),
        .valid_o(ts_valid), .dirty_o(ts_dirty), .tag_o(ts_tag), .valid_all_o(valid_all)
    );

    dmc_data #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
        .clk(clk), .idx_i(ts_idx), .off_i(ds_off),
        .we_i(ds_we), .wdata_i(ds_wdata), .rdata_o(ds_rdata)
    );
endmodule

// File: rtl/dmc_checker.sv
// Protocol and state properties of the cache, attached by bind.
// Assumes the memory side answers each request with a one-cycle mem_ack.
module dmc_checker #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 7,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              inval_go,
    input logic [(1<<IDX_W)-1:0] valid_all
);
    localparam logic [OFF_W-1:0] LAST_OFF = '1;

    // R9: completion pulse lasts one cycle.
    p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R8: a pending word holds address, direction and data until acknowledged.
    p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R8: burst words step upward inside one block.
    p_burst_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (mem_addr[OFF_W-1:0] != LAST_OFF)) |=>
        (mem_req && (mem_addr[OFF_W-1:0] == $past(mem_addr[OFF_W-1:0]) + 1'b1)
                 && (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]))));

    // R3: a completed request leaves the memory port quiet.
    p_ready_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    // R10: after an invalidate no line is valid.
    p_inval_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inval_go) |-> (valid_all == '0));
endmodule

bind dmc_cache dmc_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .inval_go(inval_go), .valid_all(valid_all)
);

// File: tb/dmc_cache_tb.sv
module dmc_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        bit          rd;
        logic [31:0] exp;
        string       req;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        flush_req = 1'b0;
    logic        inval_req = 1'b0;
    logic        maint_done;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    exp_item_t   exp_q[$];
    logic [31:0] mem_m [int];
    bit          log_we[$];
    int          log_addr[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmc_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .flush_req(flush_req), .inval_req(inval_req), .maint_done(maint_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] init_val(input int a);
        return 32'h5A00_0000 | 32'(a);
    endfunction

    function automatic logic [31:0] mem_val(input int a);
        return mem_m.exists(a) ? mem_m[a] : init_val(a);
    endfunction

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Memory model: one-cycle ack per word, logs every transfer.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                log_we.push_back(mem_we);
                log_addr.push_back(int'(mem_addr));
                if (mem_we) mem_m[int'(mem_addr)] = mem_wdata;
                else        mem_rdata <= mem_val(int'(mem_addr));
            end
        end
    end

    // Monitor: pops the scoreboard on every completion.
    always @(negedge clk) begin
        if (rst_n && cpu_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected completion", 32'(cpu_ready), 32'd0);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                if (it.rd) chk(cpu_rdata === it.exp, it.req, cpu_rdata, it.exp);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int count_ops(input bit we);
        int n = 0;
        foreach (log_we[i]) if (log_we[i] == we) n++;
        return n;
    endfunction

    task automatic clear_log();
        log_we.delete();
        log_addr.delete();
    endtask

    // Driver: queue the expectation, present the request, wait for completion.
    task automatic cpu_op(input bit we, input logic [15:0] a, input logic [31:0] d,
                          input logic [31:0] exp, input string r, output int lat);
        exp_item_t it;
        it.rd = !we; it.exp = exp; it.req = r;
        exp_q.push_back(it);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready);
        cpu_req = 1'b0;
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R9 ready one cycle", 32'(cpu_ready), 32'd0);
    endtask

    task automatic maint(input bit fl);
        @(negedge clk);
        flush_req = fl; inval_req = !fl;
        @(negedge clk);
        flush_req = 1'b0; inval_req = 1'b0;
        while (!maint_done) @(negedge clk);
        @(negedge clk);
        chk(maint_done == 1'b0, fl ? "R11 done pulse" : "R10 done pulse", 32'(maint_done), 32'd0);
    endtask

    initial begin
        int lat;
        int first_rd;
        int last_wr;
        repeat (3) @(negedge clk);
        chk(cpu_ready == 1'b0 && mem_req == 1'b0 && maint_done == 1'b0, "R4 reset outputs",
            {29'd0, cpu_ready, mem_req, maint_done}, 32'd0);
        rst_n = 1'b1;

        // Cold read miss: line 0x12, tag 0, word 3.
        clear_log();
        cpu_op(1'b0, 16'h0123, '0, init_val(16'h0123), "R2 read miss data", lat);
        chk(count_ops(1'b0) == 16, "R4 first access misses", count_ops(1'b0), 16);
        chk(count_ops(1'b1) == 0, "R2 no writes on clean miss", count_ops(1'b1), 0);
        chk(log_addr[0] == 16'h0120, "R1 refill starts at word 0", log_addr[0], 32'h0120);
        chk(log_addr[15] == 16'h012F, "R1 refill ends at word 15", log_addr[15], 32'h012F);

        // Read hit in the same block.
        clear_log();
        cpu_op(1'b0, 16'h0125, '0, init_val(16'h0125), "R3 read hit data", lat);
        chk(lat == 2, "R3 hit latency", lat, 2);
        chk(log_we.size() == 0, "R3 hit no memory", log_we.size(), 0);

        // Write hit stays in the cache.
        clear_log();
        cpu_op(1'b1, 16'h0127, 32'hDEAD_0127, '0, "R5 write hit", lat);
        chk(log_we.size() == 0, "R5 write hit no memory", log_we.size(), 0);
        chk(mem_val(16'h0127) == init_val(16'h0127), "R5 memory unchanged",
            mem_val(16'h0127), init_val(16'h0127));
        cpu_op(1'b0, 16'h0127, '0, 32'hDEAD_0127, "R5 read after write", lat);

        // Write miss allocates: line 0x45, tag 6.
        clear_log();
        cpu_op(1'b1, 16'h3456, 32'hBEEF_3456, '0, "R6 write miss", lat);
        chk(count_ops(1'b0) == 16 && count_ops(1'b1) == 0, "R6 fetch before write",
            count_ops(1'b0), 16);
        cpu_op(1'b0, 16'h3457, '0, init_val(16'h3457), "R6 neighbour word", lat);
        cpu_op(1'b0, 16'h3456, '0, 32'hBEEF_3456, "R6 written word", lat);

        // Conflict miss on dirty line 0x12: tag 1 displaces tag 0.
        clear_log();
        cpu_op(1'b0, 16'h0920, '0, init_val(16'h0920), "R7 conflict read data", lat);
        chk(count_ops(1'b1) == 16, "R7 copy-back count", count_ops(1'b1), 16);
        chk(count_ops(1'b0) == 16, "R7 refill count", count_ops(1'b0), 16);
        first_rd = -1; last_wr = -1;
        foreach (log_we[i]) begin
            if (log_we[i]) last_wr = i;
            else if (first_rd < 0) first_rd = i;
        end
        chk(last_wr < first_rd, "R7 write-back before refill", last_wr, first_rd);
        chk(log_addr[0] == 16'h0120, "R7 copy-back address", log_addr[0], 32'h0120);
        chk(mem_val(16'h0127) == 32'hDEAD_0127, "R7 memory updated",
            mem_val(16'h0127), 32'hDEAD_0127);

        // Clean victim: no write-back.
        clear_log();
        cpu_op(1'b0, 16'h0127, '0, 32'hDEAD_0127, "R7 reload data", lat);
        chk(count_ops(1'b1) == 0, "R7 clean victim no write", count_ops(1'b1), 0);

        // Flush: only line 0x45 is dirty.
        clear_log();
        maint(1'b1);
        chk(count_ops(1'b1) == 16 && count_ops(1'b0) == 0, "R11 flush writes dirty only",
            count_ops(1'b1), 16);
        chk(mem_val(16'h3456) == 32'hBEEF_3456, "R11 flushed data",
            mem_val(16'h3456), 32'hBEEF_3456);
        clear_log();
        maint(1'b1);
        chk(log_we.size() == 0, "R11 second flush idle", log_we.size(), 0);

        // Invalidate discards a modified line: line 0x77, tag 14.
        cpu_op(1'b1, 16'h7770, 32'h1234_7770, '0, "R10 setup write", lat);
        clear_log();
        maint(1'b0);
        chk(log_we.size() == 0, "R10 no write-back on invalidate", log_we.size(), 0);
        clear_log();
        cpu_op(1'b0, 16'h7770, '0, init_val(16'h7770), "R10 refetched data", lat);
        chk(count_ops(1'b0) == 16 && count_ops(1'b1) == 0, "R10 refetch after invalidate",
            count_ops(1'b0), 16);
        clear_log();
        cpu_op(1'b0, 16'h0125, '0, init_val(16'h0125), "R10 other line refetched", lat);
        chk(count_ops(1'b0) == 16, "R10 all lines invalid", count_ops(1'b0), 16);

        chk(exp_q.size() == 0, "R9 every request completed", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule